// File: doc/BRIEF.md
# Ping-Pong Spectrum Bank Controller

This block runs the time-sliced side of a pulse-height analyzer. The histogram memory has two ports and holds two banks of equal size, selected by its top address bit. The acquisition logic increments channel counts in one bank. The readout port belongs to this controller, which always points it at the other bank. A programmable slice timer counts whole milliseconds from a prescaled system clock. When a slice ends, the controller swaps the two banks together. It then streams every word of the finished bank to a byte-wide ready/valid sink, such as a USB bridge. Each word is zeroed right after it is read, so the bank is already empty when it becomes the acquisition bank again.

A start command first zeroes the whole memory, using one write per cycle. Acquisition then begins in bank 0. A stop command halts both acquisition and streaming. Reset also performs the whole-memory clear and leaves the block idle. If a slice ends while the previous bank is still being streamed, a sticky overrun flag is raised. The swap then waits for the final byte of that readout to be accepted.

Top module: `spec_bank_ctl`

## Requirements
- R1: After reset the controller writes zero to all 2*2^ADDR_W words, one word per cycle, starting at address 0. This takes 2^ADDR_W*2 cycles. During the clear `acq_en` is low. Afterwards the block is idle with `acq_bank` = 0 and the readout address top bit = 1.
- R2: `start_cmd` is accepted only while idle. It sets `acq_bank` to 0, clears `overrun`, and runs the same whole-memory clear. `acq_en` rises on the cycle after the last clear write.
- R3: The slice length is max(`slice_ms`, MIN_SLICE_MS) milliseconds, where one millisecond is TICK_DIV clock cycles. The value is sampled when acquisition begins and again at every slice boundary.
- R4: A bank swap inverts `acq_bank`. While a readout is in progress, the readout address top bit (`mb_addr[ADDR_W]`) is always the inverse of `acq_bank`.
- R5: After each swap, the finished bank is streamed in channel order 0 to 2^ADDR_W-1. Each 32-bit word goes out as four bytes, least significant byte first. `tx_data` and `tx_valid` hold steady until `tx_ready` is seen high.
- R6: Each word is read in one cycle and written with zero at the same address in the next cycle. After the last byte of a bank has been accepted, every word of that bank is zero.
- R7: If a slice ends while a readout is in progress, `overrun` is set and stays set until the next accepted start. The swap is deferred to the cycle in which the last byte of the readout is accepted.
- R8: On the cycle after `stop_cmd`, `acq_en` and `tx_valid` are low. The streaming in progress is abandoned, and no further swap happens until a new start.
- R9: `tx_valid` is low whenever no readout is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_cmd | input | 1 | One-cycle start command |
| stop_cmd | input | 1 | One-cycle stop command (wins over start) |
| slice_ms | input | 32 | Requested slice length in milliseconds |
| acq_en | output | 1 | Acquisition side may increment the memory |
| acq_bank | output | 1 | Bank bit the acquisition side must use |
| overrun | output | 1 | Sticky flag: a slice ended during a readout |
| mb_addr | output | ADDR_W+1 | Readout-port address (bank bit at the top) |
| mb_we | output | 1 | Readout-port write enable |
| mb_wdata | output | DATA_W | Readout-port write data (always zero) |
| mb_rdata | input | DATA_W | Readout-port read data, one cycle after the address |
| tx_data | output | 8 | Byte toward the host bridge |
| tx_valid | output | 1 | Byte is valid |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
A command seen at a rising edge shows at the ports one cycle later. `acq_en` rises 2*2^ADDR_W cycles after an accepted start. A swap appears on `acq_bank` at the edge that ends the slice's last millisecond tick, which is max(`slice_ms`, MIN_SLICE_MS)*TICK_DIV running cycles after the previous boundary, or later when the swap is deferred. The first byte of each word becomes valid two cycles after its address is issued. The reference model evaluates at every falling edge what the coming rising edge must do. It compares the ports against the state produced by the previous edge, so every expected value is taken from a register exactly one edge after its cause.

// File: rtl/sbk_pkg.sv
package sbk_pkg;

    localparam int SLICE_W = 32;

    typedef enum logic [1:0] {
        TOP_CLEAR = 2'd0,
        TOP_IDLE  = 2'd1,
        TOP_RUN   = 2'd2
    } top_state_e;

    typedef enum logic [1:0] {
        RO_IDLE  = 2'd0,
        RO_ADDR  = 2'd1,
        RO_CLEAR = 2'd2,
        RO_SEND  = 2'd3
    } ro_state_e;

    typedef struct packed {
        logic bank;
        logic overrun;
        logic pending;
    } bank_flags_t;

    function automatic logic [SLICE_W-1:0] clamp_slice(
        input logic [SLICE_W-1:0] req,
        input logic [SLICE_W-1:0] floor_ms
    );
        return (req < floor_ms) ? floor_ms : req;
    endfunction

endpackage

// File: rtl/sbk_slice_timer.sv
module sbk_slice_timer
    import sbk_pkg::*;
#(
    parameter int TICK_DIV     = 100000,
    parameter int MIN_SLICE_MS = 25
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               run,
    input  logic [SLICE_W-1:0] len_req,
    output logic               expire
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0]   PRE_LAST = PRE_W'(TICK_DIV - 1);
    localparam logic [SLICE_W-1:0] MIN_LEN  = SLICE_W'(MIN_SLICE_MS);

    logic [PRE_W-1:0]   pre_q;
    logic [SLICE_W-1:0] ms_q;
    logic [SLICE_W-1:0] len_q;
    logic               tick;

    assign tick   = run && (pre_q == PRE_LAST);
    assign expire = tick && (({1'b0, ms_q} + 33'd1) >= {1'b0, len_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            ms_q  <= '0;
            len_q <= MIN_LEN;
        end else if (load) begin
            pre_q <= '0;
            ms_q  <= '0;
            len_q <= clamp_slice(len_req, MIN_LEN);
        end else if (run) begin
            if (tick) begin
                pre_q <= '0;
                if (expire) begin
                    ms_q  <= '0;
                    len_q <= clamp_slice(len_req, MIN_LEN);
                end else begin
                    ms_q <= ms_q + 1'b1;
                end
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sbk_readout.sv
module sbk_readout
    import sbk_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              abort,
    input  logic              bank,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W:0]   mem_addr,
    output logic              mem_we,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              active,
    output logic              last_accept
);
    localparam int BYTES = DATA_W / 8;
    localparam int BC_W  = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [BC_W-1:0]   BC_LAST  = BC_W'(BYTES - 1);
    localparam logic [ADDR_W-1:0] IDX_LAST = '1;

    ro_state_e          st_q;
    logic [ADDR_W-1:0]  idx_q;
    logic [BC_W-1:0]    bc_q;
    logic [DATA_W-1:0]  word_q;
    logic               fire;
    logic               word_done;

    assign mem_addr    = {bank, idx_q};
    assign mem_we      = (st_q == RO_CLEAR);
    assign tx_valid    = (st_q == RO_SEND);
    assign tx_data     = word_q[7:0];
    assign active      = (st_q != RO_IDLE);
    assign fire        = tx_valid && tx_ready;
    assign word_done   = fire && (bc_q == BC_LAST);
    assign last_accept = word_done && (idx_q == IDX_LAST);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st_q   <= RO_IDLE;
            idx_q  <= '0;
            bc_q   <= '0;
            word_q <= '0;
        end else if (go) begin
            st_q  <= RO_ADDR;
            idx_q <= '0;
            bc_q  <= '0;
        end else begin
            unique case (st_q)
                RO_IDLE: ;
                RO_ADDR: st_q <= RO_CLEAR;
                RO_CLEAR: begin
                    word_q <= mem_rdata;
                    st_q   <= RO_SEND;
                end
                RO_SEND: begin
                    if (word_done) begin
                        bc_q <= '0;
                        if (idx_q == IDX_LAST) begin
                            st_q <= RO_IDLE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            st_q  <= RO_ADDR;
                        end
                    end else if (fire) begin
                        bc_q   <= bc_q + 1'b1;
                        word_q <= word_q >> 8;
                    end
                end
                default: st_q <= RO_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spec_bank_ctl.sv
module spec_bank_ctl
    import sbk_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int DATA_W       = 32,
    parameter int TICK_DIV     = 100000,
    parameter int MIN_SLICE_MS = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_cmd,
    input  logic              stop_cmd,
    input  logic [31:0]       slice_ms,
    output logic              acq_en,
    output logic              acq_bank,
    output logic              overrun,
    output logic [ADDR_W:0]   mb_addr,
    output logic              mb_we,
    output logic [DATA_W-1:0] mb_wdata,
    input  logic [DATA_W-1:0] mb_rdata,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready
);
    localparam logic [ADDR_W:0] CLR_LAST = '1;

    top_state_e      state_q;
    logic [ADDR_W:0] clr_addr_q;
    logic            clr_run_q;
    bank_flags_t     flg_q;

    logic            running;
    logic            clearing;
    logic            clr_end;
    logic            load_timer;
    logic            expire;
    logic            rd_active;
    logic            rd_last;
    logic [ADDR_W:0] rd_addr;
    logic            rd_we;
    logic            do_swap;

    assign running    = (state_q == TOP_RUN);
    assign clearing   = (state_q == TOP_CLEAR);
    assign clr_end    = clearing && (clr_addr_q == CLR_LAST);
    assign load_timer = clr_end && clr_run_q && !stop_cmd;
    assign do_swap    = running && !stop_cmd && (expire || flg_q.pending)
                        && (!rd_active || rd_last);

    sbk_slice_timer #(
        .TICK_DIV    (TICK_DIV),
        .MIN_SLICE_MS(MIN_SLICE_MS)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (load_timer),
        .run    (running),
        .len_req(slice_ms),
        .expire (expire)
    );

    sbk_readout #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_readout (
        .clk        (clk),
        .rst        (rst),
        .go         (do_swap),
        .abort      (stop_cmd),
        .bank       (~flg_q.bank),
        .mem_rdata  (mb_rdata),
        .mem_addr   (rd_addr),
        .mem_we     (rd_we),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .active     (rd_active),
        .last_accept(rd_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= TOP_CLEAR;
            clr_addr_q <= '0;
            clr_run_q  <= 1'b0;
            flg_q      <= '0;
        end else begin
            unique case (state_q)
                TOP_IDLE: begin
                    if (start_cmd && !stop_cmd) begin
                        state_q    <= TOP_CLEAR;
                        clr_addr_q <= '0;
                        clr_run_q  <= 1'b1;
                        flg_q      <= '0;
                    end
                end
                TOP_CLEAR: begin
                    clr_addr_q <= clr_addr_q + 1'b1;
                    if (stop_cmd) begin
                        clr_run_q <= 1'b0;
                    end
                    if (clr_end) begin
                        state_q <= load_timer ? TOP_RUN : TOP_IDLE;
                    end
                end
                TOP_RUN: begin
                    if (stop_cmd) begin
                        state_q       <= TOP_IDLE;
                        flg_q.pending <= 1'b0;
                    end else if (do_swap) begin
                        flg_q.bank    <= ~flg_q.bank;
                        flg_q.pending <= 1'b0;
                    end else if (expire) begin
                        flg_q.pending <= 1'b1;
                        flg_q.overrun <= 1'b1;
                    end
                end
                default: state_q <= TOP_IDLE;
            endcase
        end
    end

    assign mb_addr  = clearing ? clr_addr_q : rd_addr;
    assign mb_we    = clearing | rd_we;
    assign mb_wdata = '0;
    assign acq_en   = running;
    assign acq_bank = flg_q.bank;
    assign overrun  = flg_q.overrun;

endmodule

// File: rtl/sbk_checker.sv
module sbk_checker #(
    parameter int ADDR_W = 12
) (
    input logic            clk,
    input logic            rst,
    input logic            start_cmd,
    input logic            stop_cmd,
    input logic            acq_en,
    input logic            acq_bank,
    input logic            overrun,
    input logic [ADDR_W:0] mb_addr,
    input logic            mb_we,
    input logic            tx_valid,
    input logic            tx_ready,
    input logic [7:0]      tx_data,
    input logic            rd_active,
    input logic            rd_last
);

    AST_RD_OTHER_BANK: assert property (@(posedge clk) disable iff (rst)
        rd_active |-> (mb_addr[ADDR_W] != acq_bank)); // R4

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !stop_cmd) |=> (tx_valid && $stable(tx_data))); // R5

    AST_ZERO_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_active && mb_we) |-> (!$past(mb_we) && ($past(mb_addr) == mb_addr))); // R6

    AST_SWAP_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        (acq_en && $past(acq_en) && (acq_bank != $past(acq_bank)))
        |-> ($past(!rd_active) || $past(rd_last))); // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overrun && !start_cmd) |=> overrun); // R7

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (rst)
        stop_cmd |=> (!acq_en && !tx_valid)); // R8

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !acq_en |-> !rd_active); // R9

endmodule

bind spec_bank_ctl sbk_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_cmd(start_cmd),
    .stop_cmd (stop_cmd),
    .acq_en   (acq_en),
    .acq_bank (acq_bank),
    .overrun  (overrun),
    .mb_addr  (mb_addr),
    .mb_we    (mb_we),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .rd_active(rd_active),
    .rd_last  (rd_last)
);

// File: tb/sim_spec_bank_ctl.sv
module sim_spec_bank_ctl;
    localparam int AW    = 4;
    localparam int N     = 1 << AW;
    localparam int DIV   = 4;
    localparam int MINMS = 25;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_cmd = 1'b0;
    logic        stop_cmd = 1'b0;
    logic [31:0] slice_ms = 32'd40;
    logic        acq_en, acq_bank, overrun, mb_we, tx_valid;
    logic        tx_ready = 1'b1;
    logic [AW:0] mb_addr;
    logic [31:0] mb_wdata;
    logic [31:0] mb_rdata = '0;
    logic [7:0]  tx_data;

    always #5 clk = ~clk;

    spec_bank_ctl #(.ADDR_W(AW), .DATA_W(32), .TICK_DIV(DIV), .MIN_SLICE_MS(MINMS)) u0 (
        .clk(clk), .rst(rst), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .slice_ms(slice_ms), .acq_en(acq_en), .acq_bank(acq_bank), .overrun(overrun),
        .mb_addr(mb_addr), .mb_we(mb_we), .mb_wdata(mb_wdata), .mb_rdata(mb_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural histogram memory; the bench plays the acquisition side.
    logic [31:0]   mem [0:2*N-1];
    int            fill_ptr = 0;
    logic          hit = 1'b0;
    logic [AW-1:0] hit_ch = '0;

    always @(posedge clk) begin
        if (rst) begin
            mem[fill_ptr % (2*N)] <= 32'hC0DE_0000 | 32'(fill_ptr);
            fill_ptr <= fill_ptr + 1;
        end else begin
            if (mb_we) mem[mb_addr] <= mb_wdata;
            if (hit) mem[{acq_bank, hit_ch}] <= mem[{acq_bank, hit_ch}] + 32'd1;
        end
        mb_rdata <= mem[mb_addr];
    end

    // Ready pattern
    int ready_mode = 0;
    int cyc = 0;
    always @(posedge clk) begin
        #1;
        cyc++;
        tx_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
    end

    // Reference model
    int m_run, m_clr, m_clr_run, c_cnt, m_bank, m_ovr, m_pend, m_busy, m_bytes;
    int pre, ms, len;
    int h [2][N];
    int expq [$];
    int seed = 7;
    int seen_ovr = 0;
    int done_reads = 0;

    function automatic int clamp_len(input logic [31:0] v);
        return (v < MINMS) ? MINMS : int'(v);
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            m_clr = 1; c_cnt = 0; m_clr_run = 0; m_run = 0; m_bank = 0;
            m_ovr = 0; m_pend = 0; m_busy = 0; m_bytes = 0;
            for (int b = 0; b < 2; b++) for (int i = 0; i < N; i++) h[b][i] = 0;
            hit = 1'b0;
        end else begin
            bit fire, last_now, expire;
            chk(acq_en == m_run[0], "R2 R8 acq_en", acq_en, m_run);
            chk(acq_bank == m_bank[0], "R3 R4 acq_bank", acq_bank, m_bank);
            chk(overrun == m_ovr[0], "R7 overrun", overrun, m_ovr);
            if (!m_busy) chk(!tx_valid, "R9 tx_valid idle", tx_valid, 0);

            seed = seed * 1103515245 + 12345;
            hit    = (m_run != 0) && !stop_cmd && seed[17];
            hit_ch = seed[AW+20:21];

            fire = tx_valid && tx_ready;
            last_now = 0;
            if (stop_cmd) begin
                m_clr_run = 0; m_busy = 0; m_pend = 0;
            end
            if (m_clr) begin
                if (c_cnt == 2*N-1) begin
                    m_clr = 0;
                    if (m_clr_run) begin
                        m_run = 1; pre = 0; ms = 0; len = clamp_len(slice_ms);
                    end
                end else c_cnt++;
            end else if (stop_cmd) begin
                m_run = 0;
            end else if (start_cmd && !m_run) begin
                m_clr = 1; c_cnt = 0; m_clr_run = 1; m_bank = 0; m_ovr = 0;
                m_pend = 0; m_busy = 0;
                for (int b = 0; b < 2; b++) for (int i = 0; i < N; i++) h[b][i] = 0;
            end else if (m_run) begin
                if (hit) h[m_bank][hit_ch]++;
                if (fire) begin
                    if (!m_busy || m_bytes >= 4*N) begin
                        chk(0, "R5 unexpected byte", tx_data, -1);
                    end else begin
                        chk(int'(tx_data) == expq[m_bytes], "R5 byte", tx_data, expq[m_bytes]);
                        last_now = (m_bytes == 4*N-1);
                        m_bytes++;
                    end
                end
                if (last_now) begin
                    int nz = 0;
                    for (int i = 0; i < N; i++) if (mem[{~m_bank[0], i[AW-1:0]}] != 0) nz++;
                    chk(nz == 0, "R6 bank zero after readout", nz, 0);
                    done_reads++;
                end
                expire = 0;
                if (pre == DIV-1) begin
                    pre = 0;
                    if (ms + 1 >= len) begin
                        expire = 1; ms = 0; len = clamp_len(slice_ms);
                    end else ms++;
                end else pre++;
                if ((expire || m_pend) && (!m_busy || last_now)) begin
                    expq.delete();
                    for (int i = 0; i < N; i++) begin
                        for (int k = 0; k < 4; k++) expq.push_back((h[m_bank][i] >> (8*k)) & 255);
                        h[m_bank][i] = 0;
                    end
                    m_bank ^= 1; m_busy = 1; m_bytes = 0; m_pend = 0;
                end else begin
                    if (expire) begin m_pend = 1; m_ovr = 1; seen_ovr = 1; end
                    if (last_now) m_busy = 0;
                end
            end
        end
    end

    task automatic pulse_start();
        @(posedge clk); #1 start_cmd = 1'b1;
        @(posedge clk); #1 start_cmd = 1'b0;
    endtask

    task automatic pulse_stop();
        @(posedge clk); #1 stop_cmd = 1'b1;
        @(posedge clk); #1 stop_cmd = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (40) @(posedge clk);
        #1 rst = 1'b0;
        repeat (2*N + 4) @(posedge clk);
        #2;
        begin
            int nz = 0;
            for (int i = 0; i < 2*N; i++) if (mem[i] != 0) nz++;
            chk(nz == 0, "R1 memory cleared by reset", nz, 0);
        end
        chk(acq_bank == 1'b0, "R1 acq bank after init", acq_bank, 0);
        chk(mb_addr[AW] == 1'b1, "R1 readout bank after init", mb_addr[AW], 1);
        chk(acq_en == 1'b0, "R1 idle after init", acq_en, 0);

        pulse_start();
        repeat (450) @(posedge clk);
        #1 slice_ms = 32'd10;           // R3: below the floor, clamps
        repeat (500) @(posedge clk);
        ready_mode = 1;                 // slow sink, forces R7 overrun
        repeat (900) @(posedge clk);
        pulse_stop();
        repeat (3) @(posedge clk);
        #2 chk(!tx_valid && !acq_en, "R8 halted after stop", tx_valid, 0);
        ready_mode = 0;
        repeat (20) @(posedge clk);
        pulse_start();
        repeat (400) @(posedge clk);
        pulse_stop();
        repeat (10) @(posedge clk);
        chk(seen_ovr == 1, "R7 overrun exercised", seen_ovr, 1);
        chk(done_reads >= 4, "R5 full readouts completed", done_reads, 4);
        finish_run();
    end

endmodule